// File: doc/BRIEF.md
# Masked Message-Interrupt Aggregator

This block gathers a set of message-signalled interrupt sources (32 by default) behind a single parent interrupt line. An incoming interrupt message carries a source number. When that number is in range, the message sets that source's bit in a status vector. A per-source mask vector can hide sources from the parent line. Software manipulates the mask through separate write-one-to-set and write-one-to-clear registers. It acknowledges status bits through a write-one-to-clear register.

The interrupt handler reads an identify register. The read returns the lowest-numbered source that is pending (status set, mask clear). In the same clock edge, that source is masked and its status bit is cleared. If nothing is pending, the read returns all ones and changes nothing. A second identify register performs the same operation but returns the source translated into an operating-system vector number, which is a base (0x200 by default) plus the source number. This lets one parent interrupt cascade into a contiguous range of child vectors.

Top module: `msi_agg`

## Requirements
- R1: After reset, status and mask are all zero, `parent_irq_o` and `bus_rvalid_o` are low, and reads of STATUS (index 0) and MASK (index 1) return 0.
- R2: A message with `msg_valid_i` high and `msg_data_i` below N_SRC sets status bit `msg_data_i` at the next edge. A message carrying any larger value leaves status unchanged.
- R3: Writing index 2 sets every mask bit whose data bit is 1, and writing index 3 clears every mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged.
- R4: Writing index 4 clears every status bit whose data bit is 1. Data bits of 0 leave status unchanged.
- R5: When a message sets a status bit in the same cycle that an index-4 write or an identify clears it, the bit ends up set.
- R6: `parent_irq_o` is a register output. After every edge it equals the OR over all sources of status AND NOT mask, as those two vectors stand after that same edge.
- R7: A read (bus write flag low) returns its data on `bus_rdata_o` with `bus_rvalid_o` high in the cycle after the strobe. A read of index 5 returns the lowest-numbered pending source number.
- R8: Each identify strobe (read of index 5 or 6) that finds a pending source sets that source's mask bit and clears its status bit at the same edge, exactly once per strobe.
- R9: An identify with no pending source returns 0xFFFFFFFF and changes neither status nor mask.
- R10: A read of index 6 returns VEC_BASE plus the lowest pending source number, with the side effect of R8. With no pending source it returns all ones.
- R11: Reads of index 0 (status), 1 (mask) and 7 (status AND NOT mask) have no side effect. Reads of the write-only indices 2, 3 and 4 return 0. Writes to indices 0, 1, 5, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_valid_i | input | 1 | Decoded interrupt-message write strobe |
| msg_data_i | input | 32 | Message payload, the source number |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 3 | Register index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| parent_irq_o | output | 1 | Registered parent interrupt |

## Verification
The hardest case to reach is a collision: in a single cycle, an identify or a status-clear write targets a bit that an incoming message is setting. This is hard because the message path and the bus path are independent. The bench drives both inputs in the same cycle, with the message aimed at the source that the identify is known to select. It also sweeps shifting mixtures of status and mask patterns and drains each one with back-to-back identify reads. This checks that the lowest-first order holds and that each strobe consumes exactly one source.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS    = 3'd0,
    REG_MASK      = 3'd1,
    REG_MASK_SET  = 3'd2,
    REG_MASK_CLR  = 3'd3,
    REG_INT_CLR   = 3'd4,
    REG_IDENT     = 3'd5,
    REG_IDENT_VEC = 3'd6,
    REG_PENDING   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/msi_decode.sv
module msi_decode #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              msg_valid_i,
  input  logic [DATA_W-1:0] msg_data_i,
  output logic [N_SRC-1:0]  set_o
);
  // full-width compare rejects out-of-range source numbers
  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    assign set_o[g] = msg_valid_i && (msg_data_i == DATA_W'(g));
  end
endmodule

// File: rtl/msi_lowest.sv
module msi_lowest #(
  parameter int unsigned N     = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  logic [N-1:0] seen;

  // seen[g]: some bit below g is set
  assign seen[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_seen
    assign seen[g] = seen[g-1] | vec_i[g-1];
  end

  assign onehot_o = vec_i & ~seen;
  assign found_o  = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/msi_src_bank.sv
module msi_src_bank #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] msg_set_i,
  input  logic [N_SRC-1:0] stat_clr_i,
  input  logic [N_SRC-1:0] mask_set_i,
  input  logic [N_SRC-1:0] mask_clr_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] status_q, status_d, mask_q, mask_d;
  logic             irq_q;

  // message set takes precedence over any clear
  assign status_d = (status_q & ~stat_clr_i) | msg_set_i;
  assign mask_d   = (mask_q & ~mask_clr_i) | mask_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & ~mask_d);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  p_msg_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|msg_set_i) |=> ((status_q & $past(msg_set_i)) == $past(msg_set_i)));

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_clr_i & ~msg_set_i)) |=> ((status_q & $past(stat_clr_i & ~msg_set_i)) == '0));

  p_mask_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mask_set_i) |=> ((mask_q & $past(mask_set_i)) == $past(mask_set_i)));

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == |(status_q & ~mask_q));
endmodule

// File: rtl/msi_agg.sv
module msi_agg
  import msi_agg_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [31:0]       msg_data_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              parent_irq_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] msg_set, status, mask, pending, sel_oh;
  logic [N_SRC-1:0] wr_data, stat_clr, mask_set, mask_clr;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_found;
  logic             wr_en, rd_en, ident_rd;
  reg_sel_e         sel;
  logic [DATA_W-1:0] rd_d, rdata_q;
  logic              rvalid_q;

  assign sel      = reg_sel_e'(bus_addr_i);
  assign wr_en    = bus_valid_i &  bus_write_i;
  assign rd_en    = bus_valid_i & ~bus_write_i;
  assign ident_rd = rd_en & ((sel == REG_IDENT) | (sel == REG_IDENT_VEC));
  assign wr_data  = bus_wdata_i[N_SRC-1:0];

  msi_decode #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_decode (
    .msg_valid_i (msg_valid_i),
    .msg_data_i  (msg_data_i),
    .set_o       (msg_set)
  );

  assign pending = status & ~mask;

  msi_lowest #(.N(N_SRC)) u_lowest (
    .vec_i    (pending),
    .found_o  (sel_found),
    .idx_o    (sel_idx),
    .onehot_o (sel_oh)
  );

  // identify: mask and clear the selected source in one edge
  assign stat_clr = ((wr_en && sel == REG_INT_CLR)  ? wr_data : '0) |
                    (ident_rd ? sel_oh : '0);
  assign mask_set = ((wr_en && sel == REG_MASK_SET) ? wr_data : '0) |
                    (ident_rd ? sel_oh : '0);
  assign mask_clr =  (wr_en && sel == REG_MASK_CLR) ? wr_data : '0;

  msi_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_set_i  (msg_set),
    .stat_clr_i (stat_clr),
    .mask_set_i (mask_set),
    .mask_clr_i (mask_clr),
    .status_o   (status),
    .mask_o     (mask),
    .irq_o      (parent_irq_o)
  );

  always_comb begin
    unique case (sel)
      REG_STATUS:    rd_d = DATA_W'(status);
      REG_MASK:      rd_d = DATA_W'(mask);
      REG_PENDING:   rd_d = DATA_W'(pending);
      REG_IDENT:     rd_d = sel_found ? DATA_W'(sel_idx) : '1;
      REG_IDENT_VEC: rd_d = sel_found ? (VEC_BASE + DATA_W'(sel_idx)) : '1;
      default:       rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_d;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  p_rvalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> bus_rvalid_o);

  p_ident_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ident_rd && sel_found) |=> mask[$past(sel_idx)]);

  p_ident_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ident_rd && sel_found && !msg_set[sel_idx]) |=> !status[$past(sel_idx)]);

  p_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ident_rd && !sel_found) |=> (bus_rdata_o == '1));

  p_none_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ident_rd && !sel_found && !msg_valid_i) |=> ($stable(mask) && $stable(status)));
endmodule

// File: tb/tb_msi_agg.sv
`timescale 1ns/1ps
module tb_msi_agg;
  localparam logic [31:0] VBASE = 32'h200;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_valid_i = 1'b0;
  logic [31:0] msg_data_i = '0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_rvalid_o;
  logic        parent_irq_o;

  int n_vec = 0;
  int n_err = 0;
  logic [31:0] m_st = '0, m_mk = '0;

  always #4 clk = ~clk;

  msi_agg dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .msg_valid_i(msg_valid_i), .msg_data_i(msg_data_i),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
    .parent_irq_o(parent_irq_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = -1;
  endfunction

  // one cycle; called just after a negedge
  task automatic op(input logic mv, input logic [31:0] md, input logic bv, input logic bw,
                    input logic [2:0] ba, input logic [31:0] bd, input string tag);
    logic [31:0] pend, exp_rd, clr, bit_l;
    int lo;
    pend = m_st & ~m_mk;
    lo = lowest(pend);
    bit_l = (lo >= 0) ? (32'd1 << lo) : 32'd0;
    case (ba)
      3'd0: exp_rd = m_st;
      3'd1: exp_rd = m_mk;
      3'd7: exp_rd = pend;
      3'd5: exp_rd = (lo >= 0) ? 32'(lo) : 32'hFFFF_FFFF;
      3'd6: exp_rd = (lo >= 0) ? VBASE + 32'(lo) : 32'hFFFF_FFFF;
      default: exp_rd = 32'd0;
    endcase
    msg_valid_i = mv; msg_data_i = md;
    bus_valid_i = bv; bus_write_i = bw; bus_addr_i = ba; bus_wdata_i = bd;
    @(posedge clk);
    @(negedge clk);
    msg_valid_i = 1'b0; bus_valid_i = 1'b0;
    clr = 32'd0;
    if (bv && bw && ba == 3'd2) m_mk = m_mk | bd;
    if (bv && bw && ba == 3'd3) m_mk = m_mk & ~bd;
    if (bv && bw && ba == 3'd4) clr = bd;
    if (bv && !bw && (ba == 3'd5 || ba == 3'd6)) begin
      m_mk = m_mk | bit_l;
      clr  = clr | bit_l;
    end
    m_st = m_st & ~clr;
    if (mv && md < 32) m_st = m_st | (32'd1 << md);
    chk(tag, "rvalid", 32'(bus_rvalid_o), 32'(bv && !bw));
    if (bv && !bw) chk(tag, "rdata", bus_rdata_o, exp_rd);
    chk("R6", "parent_irq", 32'(parent_irq_o), 32'(|(m_st & ~m_mk)));
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    op(1'b0, 0, 1'b1, 1'b0, a, 0, tag);
  endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    op(1'b0, 0, 1'b1, 1'b1, a, d, tag);
  endtask
  task automatic msg(input logic [31:0] d, input string tag);
    op(1'b1, d, 1'b0, 1'b0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [31:0] lfsr, pat, msk;
    repeat (3) @(negedge clk);
    chk("R1", "irq in reset", 32'(parent_irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "rvalid after reset", 32'(bus_rvalid_o), 0);
    rd(3'd0, "R1");
    rd(3'd1, "R1");

    // R2 R7 R8: each source alone
    for (int i = 0; i < 32; i++) begin
      msg(i, "R2");
      rd(3'd0, "R2");
      rd(3'd5, "R7");
      rd(3'd1, "R8");
      rd(3'd0, "R8");
      wr(3'd3, 32'd1 << i, "R3");
    end

    // R2: out-of-range messages ignored
    msg(32, "R2");
    msg(32'h200, "R2");
    msg(32'hFFFF_FFFF, "R2");
    rd(3'd0, "R2");

    // R9: empty identify
    rd(3'd5, "R9");
    rd(3'd6, "R9");
    rd(3'd1, "R9");

    // R3 R4: zero writes have no effect
    msg(3, "R2"); msg(17, "R2");
    wr(3'd2, 32'h0000_0F00, "R3");
    wr(3'd2, 0, "R3");  rd(3'd1, "R3");
    wr(3'd3, 0, "R3");  rd(3'd1, "R3");
    wr(3'd3, 32'h0000_0300, "R3"); rd(3'd1, "R3");
    wr(3'd4, 0, "R4");  rd(3'd0, "R4");
    wr(3'd4, 32'h0000_0008, "R4"); rd(3'd0, "R4");

    // R11: peek reads have no side effect, write-only reads 0, writes to read regs ignored
    rd(3'd7, "R11"); rd(3'd7, "R11"); rd(3'd0, "R11"); rd(3'd1, "R11");
    rd(3'd2, "R11"); rd(3'd3, "R11"); rd(3'd4, "R11");
    wr(3'd0, 32'hFFFF_FFFF, "R11"); wr(3'd1, 32'hFFFF_FFFF, "R11");
    wr(3'd5, 32'hFFFF_FFFF, "R11"); wr(3'd7, 32'hFFFF_FFFF, "R11");
    rd(3'd0, "R11"); rd(3'd1, "R11");

    // R5: message beats clear write
    wr(3'd4, 32'hFFFF_FFFF, "R4"); wr(3'd3, 32'hFFFF_FFFF, "R3");
    op(1'b1, 5, 1'b1, 1'b1, 3'd4, 32'h0000_0020, "R5");
    rd(3'd0, "R5");
    // R5: message on the source that identify selects
    op(1'b1, 5, 1'b1, 1'b0, 3'd5, 0, "R5");
    rd(3'd0, "R5"); rd(3'd1, "R5"); rd(3'd7, "R5");

    // R7 R8 R10: pattern sweep drained by identify
    lfsr = 32'hACE1_1357;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pat = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      msk = lfsr & {lfsr[15:0], lfsr[31:16]};
      wr(3'd4, 32'hFFFF_FFFF, "R4");
      wr(3'd3, 32'hFFFF_FFFF, "R3");
      for (int b = 0; b < 32; b++) if (pat[b]) msg(b, "R2");
      wr(3'd2, msk, "R3");
      rd(3'd7, "R11");
      for (int j = 0; j < 34; j++) rd((j % 2) ? 3'd6 : 3'd5, (j % 2) ? "R10" : "R8");
      rd(3'd0, "R8");
      rd(3'd1, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule